// File: doc/BRIEF.md
# Dual-Modulus Swallow-Counter Divider

This block is the programmable feedback divider of one synthesizer channel. It is clocked by the prescaler input. Inside it, a fixed divide-by-2 stage feeds a divide-by-32/33 stage, which gives an effective prescaler of 64 or 66. A swallow count A (5 bits) and a main count B (12 bits) decide how many prescaler periods use each modulus. Each time a full division cycle of N = 2·(32·B + A) input clocks completes, the block emits a single-clock pulse. N is always even.

At each cycle boundary both counts reload from the parallel inputs `a_word` and `b_word`. The prescaler runs at 66 for the first A periods and at 64 for the remaining B−A periods. Words changed in the middle of a cycle are picked up only at the next boundary. Dropping `en` puts the channel into standby: the counters are held at their reload values and the output stays low. An illegal setting raises `cfg_err` and is forced to the nearest legal one.

Top module: `swallow_div`

## Requirements
- R1: While running, `div_pulse` is high for exactly one clock once every 2·(32·B + A) clocks. Example settings: B=3/A=0 gives 192, B=5/A=2 gives 324, B=566/A=8 gives 36240, B=578/A=20 gives 37032.
- R2: After `en` rises, the first `div_pulse` is registered on the N-th rising clock edge at which `en` is high.
- R3: While `en` is low, `div_pulse` stays low and no division progress is kept. Every restart begins a fresh cycle.
- R4: If `a_word`/`b_word` change during a cycle, that cycle keeps its old length. The new ratio applies from the following cycle on.
- R5: When `b_word` < 3, `cfg_err` is high and B is treated as 3.
- R6: When `a_word` > `b_word`, `cfg_err` is high and A is treated as equal to the effective B.
- R7: A = B is legal: `cfg_err` stays low and every prescaler period uses modulus 66 (B=3/A=3 gives 198).
- R8: While `rst_n` is low, `div_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel run enable; low means standby |
| a_word | input | 5 | Swallow count A |
| b_word | input | 12 | Main count B |
| div_pulse | output | 1 | One-clock pulse per division cycle |
| cfg_err | output | 1 | High while the A/B pair is illegal |

## Verification
The bench measures the exact gap between pulses for the smallest ratios and for both large worked settings. A modulus stage off by one period, or a swallow count applied to the wrong periods, would show up as a gap a few clocks too long or too short. It changes the words in the middle of a cycle and expects one more gap at the old length before the new one. A design that reloads immediately would produce a truncated or stretched gap. It also drives B below 3 and A above B, including the A = B edge case. Wrong clamping would give a wrong period or a spurious error flag. Finally it checks that standby silences the output and that a restart restarts the count from zero rather than resuming a partial cycle.

// File: rtl/swallow_div.sv
module swallow_div #(
  parameter int AW   = 5,
  parameter int BW   = 12,
  parameter int PW   = 5,
  parameter int BMIN = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] a_word,
  input  logic [BW-1:0] b_word,
  output logic          div_pulse,
  output logic          cfg_err
);
  localparam int PMOD = 1 << PW;

  logic          ph;
  logic [PW:0]   pc;
  logic [AW-1:0] sc;
  logic [BW-1:0] mc;

  logic          b_low, a_high;
  logic [BW-1:0] b_eff;
  logic [AW-1:0] a_eff;
  logic          pc_last, period_end, cyc_end;

  assign b_low   = b_word < BW'(BMIN);
  assign b_eff   = b_low ? BW'(BMIN) : b_word;
  assign a_high  = {{(BW-AW){1'b0}}, a_word} > b_eff;
  assign a_eff   = a_high ? b_eff[AW-1:0] : a_word;
  assign cfg_err = b_low | a_high;

  assign pc_last    = (pc == ((sc != '0) ? (PW+1)'(PMOD) : (PW+1)'(PMOD-1)));
  assign period_end = ph & pc_last;
  assign cyc_end    = period_end & (mc == BW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= 1'b0;
      pc <= '0;
      sc <= '0;
      mc <= BW'(BMIN);
      div_pulse <= 1'b0;
    end else if (!en) begin
      ph <= 1'b0;
      pc <= '0;
      sc <= a_eff;
      mc <= b_eff;
      div_pulse <= 1'b0;
    end else begin
      ph <= ~ph;
      div_pulse <= cyc_end;
      if (ph) begin
        if (pc_last) begin
          pc <= '0;
          if (cyc_end) begin
            sc <= a_eff;
            mc <= b_eff;
          end else begin
            mc <= mc - BW'(1);
            if (sc != '0) sc <= sc - AW'(1);
          end
        end else begin
          pc <= pc + (PW+1)'(1);
        end
      end
    end
  end

  p_standby_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !div_pulse);
  p_pulse_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);
  p_swallow_le_main_r6: assert property (@(posedge clk) disable iff (!rst_n)
    {{(BW-AW){1'b0}}, sc} <= mc);
  p_main_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mc != '0);
  p_modulus_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pc <= (PW+1)'(PMOD));
endmodule

// File: tb/swallow_div_tb_top.sv
module swallow_div_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [4:0] a_word = '0;
  logic [11:0] b_word = 12'd3;
  logic div_pulse, cfg_err;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  swallow_div dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .a_word(a_word), .b_word(b_word),
    .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!div_pulse && n < 50000);
  endtask

  task automatic set_words(input int a, input int b);
    @(negedge clk);
    en = 1'b0;
    a_word = 5'(a);
    b_word = 12'(b);
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R8 pulse in reset", div_pulse, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_ratio(input int a, input int b, input int exp_err, input int exp_n, input string req);
    int n;
    set_words(a, b);
    check({req, " err flag"}, cfg_err, exp_err);
    gap(n);
    check({req, " first pulse R2"}, n, exp_n);
    gap(n);
    check({req, " period"}, n, exp_n);
    @(negedge clk);
    check("R1 pulse width", div_pulse, 0);
  endtask

  task automatic t_midcycle;
    int n;
    set_words(0, 5);
    gap(n);
    repeat (49) @(negedge clk);
    a_word = 5'd1;
    b_word = 12'd4;
    gap(n);
    n += 49;
    check("R4 old ratio kept", n, 320);
    gap(n);
    check("R4 new ratio applied", n, 258);
  endtask

  task automatic t_standby;
    int seen = 0;
    int n;
    set_words(0, 3);
    repeat (100) @(negedge clk);
    en = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (div_pulse) seen++;
    end
    check("R3 quiet in standby", seen, 0);
    en = 1'b1;
    gap(n);
    check("R3 fresh restart", n, 192);
  endtask

  initial begin
    t_reset();
    t_ratio(0, 3, 0, 192, "R1 B3A0");
    t_ratio(2, 5, 0, 324, "R1 B5A2");
    t_ratio(3, 3, 0, 198, "R7 A eq B");
    t_ratio(8, 566, 0, 36240, "R1 B566A8");
    t_ratio(20, 578, 0, 37032, "R1 B578A20");
    t_ratio(0, 1, 1, 192, "R5 B low");
    t_ratio(5, 0, 1, 198, "R5 R6 B zero A5");
    t_ratio(20, 10, 1, 660, "R6 A high");
    t_midcycle();
    t_standby();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule